// File: doc/BRIEF.md
# Addressed Almost-Empty Status Quadrant Selector

This block takes one almost-empty flag per queue, for up to 32 queues, and shows eight of them at a time on an 8-bit status bus. The queues are split into four quadrants of eight. A host picks the quadrant to show by writing a read address on the read clock, qualified by a strobe. The low two address bits name the quadrant. The upper three bits name a device, so several devices can share one status bus.

A device answers a selection only when the address's device bits equal its static ID inputs. It releases the shared bus by dropping an output enable whenever the most recent selection named another device. The block is told how many queues are configured. Status lines for queues that are not configured are forced low. With eight or fewer queues configured, the first quadrant stays on the bus whatever the selection.

The block also reports a protocol error when a quadrant selection and a read-queue selection arrive on the same cycle. The flags are computed elsewhere and arrive here as plain inputs.

Top module: `ae_quad_top`

## Requirements
- R1: Address bits [1:0] choose the quadrant: 0 shows queues 0–7, 1 shows 8–15, 2 shows 16–23 and 3 shows 24–31. Status line i carries queue (quadrant*8 + i).
- R2: A selection sampled at a clock edge shows on `stat_bus` right after that edge, so the result is visible one cycle after the request. A new quadrant may be chosen on every consecutive cycle.
- R3: A selection takes effect only when address bits [4:2] equal `dev_id`. A selection that does not match leaves the quadrant unchanged and drives `stat_oe` low from the next cycle. It stays low until a matching selection arrives.
- R4: While `sel_stb` is low, `sel_addr` has no effect on `stat_bus` or `stat_oe`.
- R5: A status line whose queue index is equal to or above `qcount` is driven 0.
- R6: When `qcount` is 8 or less, queues 0–7 are shown whatever quadrant was selected.
- R7: `proto_err` is high for exactly the cycle after an edge at which `sel_stb` and `rdq_stb` were both high, and low otherwise.
- R8: While `rst` is high, `stat_bus`, `stat_oe` and `proto_err` are 0. After reset the selection behaves as if address 0 had been chosen: quadrant 0 is shown and `stat_oe` equals (`dev_id` == 0).
- R9: With no new selection, `stat_bus` follows changes of `ae_flags` and `qcount` with a lag of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| ae_flags | input | 32 | Almost-empty flag per queue |
| qcount | input | 6 | Number of configured queues (0–32) |
| dev_id | input | 3 | Static device identity |
| sel_stb | input | 1 | Qualifies a quadrant selection |
| sel_addr | input | 5 | {device bits, quadrant bits} |
| rdq_stb | input | 1 | Read-queue selection strobe, used only for the protocol check |
| stat_bus | output | 8 | Flags of the selected quadrant, registered |
| stat_oe | output | 1 | Drive enable for the shared status bus |
| proto_err | output | 1 | Selection and read-queue strobe collided |

## Verification
Every output is registered once. The result of any input is therefore due exactly one cycle after the clock edge that samples it. This holds for a selection, a flag change, a change of the configured count and a strobe collision alike. The bench drives its inputs just after a falling edge. At the next rising edge it advances a reference model that holds only the selected quadrant and the last device bits seen. It then compares the outputs at the following falling edge, so every check looks at the value due one cycle after its stimulus.

// File: rtl/ae_quad_pkg.sv
package ae_quad_pkg;
  localparam int DEF_NUM_Q = 32;
  localparam int DEF_GRP   = 8;
  localparam int DEF_ID_W  = 3;

  // Flat queue index behind a status line.
  function automatic int line_queue(input int quad, input int line, input int grp);
    return quad * grp + line;
  endfunction
endpackage

// File: rtl/ae_quad_decode.sv
module ae_quad_decode #(
  parameter int ID_W  = 3,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_stb,
  input  logic [ID_W+SEL_W-1:0] sel_addr,
  input  logic [ID_W-1:0]       dev_id,
  output logic [SEL_W-1:0]      quad_nxt,
  output logic                  hit_nxt
);
  localparam int ADDR_W = ID_W + SEL_W;

  logic [SEL_W-1:0] quad_q;
  logic [ID_W-1:0]  hi_q;
  logic [ID_W-1:0]  addr_hi;
  logic [SEL_W-1:0] addr_lo;

  assign addr_hi = sel_addr[ADDR_W-1:SEL_W];
  assign addr_lo = sel_addr[SEL_W-1:0];

  always_comb begin
    quad_nxt = quad_q;
    if (sel_stb && (addr_hi == dev_id)) quad_nxt = addr_lo;
    hit_nxt = ((sel_stb ? addr_hi : hi_q) == dev_id);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_q <= '0;
      hi_q   <= '0;
    end else begin
      quad_q <= quad_nxt;
      if (sel_stb) hi_q <= addr_hi;
    end
  end

  // R4: no strobe, no change of the held selection
  assert_hold_sel_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_stb |=> (quad_q == $past(quad_q)) && (hi_q == $past(hi_q)));
  // R3: a foreign selection keeps the quadrant
  assert_foreign_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_stb && (addr_hi != dev_id)) |=> quad_q == $past(quad_q));
endmodule

// File: rtl/ae_quad_mux.sv
module ae_quad_mux
  import ae_quad_pkg::*;
#(
  parameter int NUM_Q = 32,
  parameter int GRP   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_Q-1:0]            ae_flags,
  input  logic [$clog2(NUM_Q+1)-1:0]  qcount,
  input  logic [$clog2(NUM_Q/GRP)-1:0] quad,
  output logic [GRP-1:0]              stat_bus
);
  localparam int NUM_GRP = NUM_Q / GRP;
  localparam int SEL_W   = $clog2(NUM_GRP);

  logic             small_cfg;
  logic [SEL_W-1:0] quad_eff;
  logic [GRP-1:0]   bus_d;

  assign small_cfg = (int'(qcount) <= GRP);
  assign quad_eff  = small_cfg ? '0 : quad;

  for (genvar i = 0; i < GRP; i++) begin : g_line
    always_comb begin
      bus_d[i] = 1'b0;
      for (int q = 0; q < NUM_GRP; q++) begin
        if (int'(quad_eff) == q && line_queue(q, i, GRP) < int'(qcount))
          bus_d[i] = ae_flags[line_queue(q, i, GRP)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_bus <= '0;
    else     stat_bus <= bus_d;
  end

  // R5: nothing configured, nothing shown
  assert_empty_cfg_R5: assert property (@(posedge clk) disable iff (rst)
    (qcount == '0) |=> stat_bus == '0);
  // R9: steady inputs and selection give a steady bus
  assert_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(ae_flags) && $stable(qcount) && $stable(quad)) |=> $stable(stat_bus));
endmodule

// File: rtl/ae_quad_top.sv
module ae_quad_top
  import ae_quad_pkg::*;
#(
  parameter int NUM_Q = DEF_NUM_Q,
  parameter int GRP   = DEF_GRP,
  parameter int ID_W  = DEF_ID_W
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_Q-1:0]                      ae_flags,
  input  logic [$clog2(NUM_Q+1)-1:0]            qcount,
  input  logic [ID_W-1:0]                       dev_id,
  input  logic                                  sel_stb,
  input  logic [ID_W+$clog2(NUM_Q/GRP)-1:0]     sel_addr,
  input  logic                                  rdq_stb,
  output logic [GRP-1:0]                        stat_bus,
  output logic                                  stat_oe,
  output logic                                  proto_err
);
  localparam int SEL_W  = $clog2(NUM_Q / GRP);
  localparam int ADDR_W = ID_W + SEL_W;

  logic [SEL_W-1:0] quad_nxt;
  logic             hit_nxt;

  ae_quad_decode #(.ID_W(ID_W), .SEL_W(SEL_W)) u_dec (
    .clk(clk), .rst(rst), .sel_stb(sel_stb), .sel_addr(sel_addr),
    .dev_id(dev_id), .quad_nxt(quad_nxt), .hit_nxt(hit_nxt)
  );

  ae_quad_mux #(.NUM_Q(NUM_Q), .GRP(GRP)) u_mux (
    .clk(clk), .rst(rst), .ae_flags(ae_flags), .qcount(qcount),
    .quad(quad_nxt), .stat_bus(stat_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_oe   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      stat_oe   <= hit_nxt;
      proto_err <= sel_stb && rdq_stb;
    end
  end

  // R3: selection naming another device releases the bus
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_stb && (sel_addr[ADDR_W-1:SEL_W] != dev_id)) |=> !stat_oe);
  // R3: selection naming this device claims the bus
  assert_claim_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_stb && (sel_addr[ADDR_W-1:SEL_W] == dev_id)) |=> stat_oe);
  // R7: collision flagged
  assert_collide_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_stb && rdq_stb) |=> proto_err);
  // R7: no collision, no flag
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !(sel_stb && rdq_stb) |=> !proto_err);
  // R8: outputs cleared while held in reset
  assert_reset_R8: assert property (@(posedge clk)
    $past(rst) |-> (stat_bus == '0 && !stat_oe && !proto_err));
endmodule

// File: tb/ae_quad_top_test.sv
module ae_quad_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ae_flags = '0;
  logic [5:0]  qcount = 6'd32;
  logic [2:0]  dev_id = 3'd5;
  logic        sel_stb = 1'b0;
  logic [4:0]  sel_addr = '0;
  logic        rdq_stb = 1'b0;
  logic [7:0]  stat_bus;
  logic        stat_oe;
  logic        proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_quad = 0;
  int m_hi   = 0;
  logic [7:0] e_bus;
  logic       e_oe, e_err;

  always #2 clk = ~clk;

  ae_quad_top uut (
    .clk(clk), .rst(rst), .ae_flags(ae_flags), .qcount(qcount), .dev_id(dev_id),
    .sel_stb(sel_stb), .sel_addr(sel_addr), .rdq_stb(rdq_stb),
    .stat_bus(stat_bus), .stat_oe(stat_oe), .proto_err(proto_err)
  );

  function automatic logic [7:0] ref_bus(input logic [31:0] f, input int q, input int qc);
    logic [7:0] r;
    int qq;
    qq = (qc <= 8) ? 0 : q;
    for (int i = 0; i < 8; i++) r[i] = (qq * 8 + i < qc) ? f[qq * 8 + i] : 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, advance model at rising edge, compare at the next falling edge.
  task automatic step(input logic [31:0] f, input int qc, input logic stb,
                      input logic [4:0] a, input logic rdq, input string req);
    ae_flags = f; qcount = qc[5:0]; sel_stb = stb; sel_addr = a; rdq_stb = rdq;
    @(posedge clk);
    if (stb) begin
      if (int'(a[4:2]) == int'(dev_id)) m_quad = int'(a[1:0]);
      m_hi = int'(a[4:2]);
    end
    e_bus = ref_bus(f, m_quad, qc);
    e_oe  = (m_hi == int'(dev_id));
    e_err = stb && rdq;
    @(negedge clk);
    check({req, " bus"}, stat_bus, e_bus);
    check({req, " oe"}, {7'd0, stat_oe}, {7'd0, e_oe});
    check({req, " err"}, {7'd0, proto_err}, {7'd0, e_err});
  endtask

  task automatic do_reset(input logic [2:0] id);
    rst = 1'b1; dev_id = id; sel_stb = 1'b0; rdq_stb = 1'b0;
    ae_flags = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R8 reset bus", stat_bus, 8'h00);
    check("R8 reset oe/err", {6'd0, stat_oe, proto_err}, 8'h00);
    rst = 1'b0;
    m_quad = 0; m_hi = 0;
  endtask

  initial begin
    @(negedge clk);
    // R8 with a device whose ID is zero: bus claimed after reset
    do_reset(3'd0);
    step(32'hA5C3_9617, 32, 1'b0, 5'd0, 1'b0, "R8 post-reset id0");
    // R8 with a nonzero ID: bus released after reset
    do_reset(3'd5);
    step(32'hA5C3_9617, 32, 1'b0, 5'd0, 1'b0, "R8 post-reset id5");
    // R1 / R2: each quadrant on consecutive cycles
    for (int q = 0; q < 4; q++)
      step(32'h8421_F00D, 32, 1'b1, {3'd5, q[1:0]}, 1'b0, "R1 R2 quadrant");
    // R3: foreign selection releases, quadrant held
    step(32'h8421_F00D, 32, 1'b1, {3'd2, 2'd0}, 1'b0, "R3 foreign");
    step(32'h1234_5678, 32, 1'b0, 5'd0, 1'b0, "R3 still released");
    step(32'h1234_5678, 32, 1'b1, {3'd5, 2'd1}, 1'b0, "R3 reclaim");
    // R4: address moves without strobe
    step(32'h1234_5678, 32, 1'b0, {3'd5, 2'd3}, 1'b0, "R4 ignored addr");
    step(32'h1234_5678, 32, 1'b0, {3'd1, 2'd0}, 1'b0, "R4 ignored id");
    // R5: 26 queues, last quadrant shows lines 0-1 only
    step(32'hFFFF_FFFF, 26, 1'b1, {3'd5, 2'd3}, 1'b0, "R5 26 queues");
    step(32'hFFFF_FFFF, 0, 1'b0, 5'd0, 1'b0, "R5 none configured");
    // R6: eight or fewer queues freeze quadrant 0
    step(32'hF0F0_F0A5, 8, 1'b1, {3'd5, 2'd2}, 1'b0, "R6 eight queues");
    step(32'hF0F0_F0A5, 5, 1'b1, {3'd5, 2'd3}, 1'b0, "R6 five queues");
    // R7: collision and its absence
    step(32'h0, 32, 1'b1, {3'd5, 2'd2}, 1'b1, "R7 collision");
    step(32'h0, 32, 1'b0, 5'd0, 1'b1, "R7 read only");
    // R9: flag change without selection
    step(32'h00FF_0000, 32, 1'b0, 5'd0, 1'b0, "R9 flags follow");
    step(32'h00AA_0000, 32, 1'b0, 5'd0, 1'b0, "R9 flags follow");
    // Random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      int qc, pick;
      logic [4:0] a;
      pick = $urandom_range(0, 4);
      qc = (pick == 0) ? 26 : (pick == 1) ? 8 : (pick == 2) ? 32 : $urandom_range(0, 32);
      a[1:0] = 2'($urandom_range(0, 3));
      a[4:2] = ($urandom_range(0, 9) < 7) ? 3'd5 : 3'($urandom_range(0, 7));
      step($urandom(), qc, 1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)), "R1-mix");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule